// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block settles, within a single combinational pass, whether a conditional branch in a 64-bit core is taken and where it goes. It evaluates two tests. The first is a condition test against one bit of the 32-bit condition register. The second is a test of the count register against zero, which can be limited to the low 32 bits when the core runs in 32-bit mode. In the same pass it produces the decremented count, a flag that says whether that count must be written back, and the link address with its own write flag.

The target comes from one of four sources, held in an enumerated selector:
- `TGT_REL` adds a scaled, sign-extended displacement to the current address.
- `TGT_ABS` uses that displacement alone.
- `TGT_SPR_A` and `TGT_SPR_B` take one of two special-register inputs with the two low bits cleared.

Which special register is used depends on two extended-opcode bits. The surrounding pipeline provides decoded fields, and it takes the next-address output only when the valid flag is high.

Top module: `bru_top`

## Requirements
- R1: The condition test passes when `bo[4]` is 1, or when condition-register bit `cr[31 - bi]` (bit 0 is the least significant) equals `bo[3]`.
- R2: The count test passes when `bo[2]` is 1, or when (count nonzero) XOR `bo[1]` is 1.
- R3: When `mode32` is 1, the count's zero test looks only at `ctr_in[31:0]`. When `mode32` is 0, it looks at all 64 bits.
- R4: When `bo[2]` is 0, `ctr_out` equals `ctr_in - 1` modulo 2^64, so 0 becomes all ones. When `bo[2]` is 1, `ctr_out` equals `ctr_in`.
- R5: `ctr_we` is 1 exactly when `bo[2]` is 0.
- R6: `nia_valid` is 1 exactly when both the condition test and the count test pass.
- R7: With `indirect` = 1, the target is `spr_a` when `xo_sel[1]` (extended-opcode bit 9) is 1 and `xo_sel[0]` (extended-opcode bit 5) is 0. In every other case the target is `spr_b`.
- R8: An indirect target is driven on `nia` with bits [1:0] forced to 0.
- R9: With `indirect` = 0, the target is `{disp, 2'b00}` sign-extended to 64 bits. It is added to `cia` when `absolute` = 0 and used alone when `absolute` = 1.
- R10: `lr_we` equals `lk`, and `lr_value` equals `cia + 4`.
- R11: With all inputs at zero, the outputs are `nia` = 0, `nia_valid` = 0, `ctr_out` = all ones, `ctr_we` = 1, `lr_we` = 0 and `lr_value` = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cia | input | 64 | Address of the current instruction |
| indirect | input | 1 | 1 selects a target from a special register |
| absolute | input | 1 | 1 makes a direct target absolute |
| disp | input | 14 | Word displacement for direct targets |
| xo_sel | input | 2 | Extended-opcode bits 9 (bit 1) and 5 (bit 0) |
| bo | input | 5 | Branch-options field |
| bi | input | 5 | Condition-register bit index |
| lk | input | 1 | Link-request bit |
| mode32 | input | 1 | 1 selects 32-bit mode for the count test |
| cr | input | 32 | Condition register |
| ctr_in | input | 64 | Current count register |
| spr_a | input | 64 | First special-register target source |
| spr_b | input | 64 | Second special-register target source |
| nia | output | 64 | Next instruction address |
| nia_valid | output | 1 | Branch taken; `nia` is valid |
| lr_we | output | 1 | Link-register write enable |
| lr_value | output | 64 | Link value |
| ctr_out | output | 64 | Updated count |
| ctr_we | output | 1 | Count-register write enable |

## Verification
The count update and the taken decision always fall in the same evaluation, and the decision also depends on the pre-update count. Near the zero boundary, an error in either one can hide the other. The bench sweeps every `bo` value against counts of 0, 1, all ones and a value that is nonzero only above bit 31, in both modes. For each case it computes `nia_valid`, `ctr_out` and `ctr_we` arithmetically and compares all three.

// File: rtl/bru_pkg.sv
package bru_pkg;
    parameter int ADDR_W  = 64;
    parameter int CR_W    = 32;
    parameter int HALF_W  = 32;
    parameter int DISP_W  = 14;
    parameter int FIELD_W = 5;
    parameter int LINK_STEP = 4;

    typedef enum logic [1:0] {
        TGT_REL   = 2'd0,
        TGT_ABS   = 2'd1,
        TGT_SPR_A = 2'd2,
        TGT_SPR_B = 2'd3
    } tgt_src_e;
endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval #(
    parameter int CR_W    = bru_pkg::CR_W,
    parameter int FIELD_W = bru_pkg::FIELD_W
) (
    input  logic [FIELD_W-1:0] bo,
    input  logic [FIELD_W-1:0] bi,
    input  logic [CR_W-1:0]    cr,
    output logic               cond_ok
);
    localparam logic [FIELD_W-1:0] TOP_IDX = FIELD_W'(CR_W - 1);

    logic [FIELD_W-1:0] bit_idx;
    logic               sel_bit;

    always_comb begin
        bit_idx = TOP_IDX - bi;
        sel_bit = cr[bit_idx];
        cond_ok = bo[4] | (sel_bit == bo[3]);
    end

    always_comb begin
        if (bo[4]) begin
            AST_COND_IGNORE: assert (cond_ok); // R1
        end
    end
endmodule

// File: rtl/bru_ctr_unit.sv
module bru_ctr_unit #(
    parameter int ADDR_W  = bru_pkg::ADDR_W,
    parameter int HALF_W  = bru_pkg::HALF_W,
    parameter int FIELD_W = bru_pkg::FIELD_W
) (
    input  logic [FIELD_W-1:0] bo,
    input  logic               mode32,
    input  logic [ADDR_W-1:0]  ctr_in,
    output logic [ADDR_W-1:0]  ctr_out,
    output logic               ctr_we,
    output logic               ctr_ok
);
    logic low_nz;
    logic high_nz;
    logic cnt_nz;

    always_comb begin
        low_nz  = |ctr_in[HALF_W-1:0];
        high_nz = |ctr_in[ADDR_W-1:HALF_W];
        cnt_nz  = mode32 ? low_nz : (low_nz | high_nz);
        ctr_ok  = bo[2] | (cnt_nz ^ bo[1]);
        ctr_we  = ~bo[2];
        ctr_out = bo[2] ? ctr_in : (ctr_in - ADDR_W'(1));
    end

    always_comb begin
        if (ctr_we) begin
            AST_CTR_STEP: assert (ctr_out + ADDR_W'(1) == ctr_in); // R4
        end else begin
            AST_CTR_HOLD: assert (ctr_out == ctr_in); // R4
        end
    end
endmodule

// File: rtl/bru_target_sel.sv
module bru_target_sel #(
    parameter int ADDR_W = bru_pkg::ADDR_W,
    parameter int DISP_W = bru_pkg::DISP_W
) (
    input  logic               indirect,
    input  logic               absolute,
    input  logic [1:0]         xo_sel,
    input  logic [DISP_W-1:0]  disp,
    input  logic [ADDR_W-1:0]  cia,
    input  logic [ADDR_W-1:0]  spr_a,
    input  logic [ADDR_W-1:0]  spr_b,
    output logic [ADDR_W-1:0]  target
);
    import bru_pkg::*;

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

    tgt_src_e          src;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ADDR_W'($signed({disp, 2'b00}));
        if (indirect) begin
            src = (xo_sel[1] & ~xo_sel[0]) ? TGT_SPR_A : TGT_SPR_B;
        end else begin
            src = absolute ? TGT_ABS : TGT_REL;
        end
    end

    always_comb begin
        unique case (src)
            TGT_REL:   target = cia + offset;
            TGT_ABS:   target = offset;
            TGT_SPR_A: target = spr_a & ALIGN_MASK;
            TGT_SPR_B: target = spr_b & ALIGN_MASK;
            default:   target = '0;
        endcase
    end

    always_comb begin
        if (indirect) begin
            AST_IND_ALIGN: assert (target[1:0] == 2'b00); // R8
        end
    end
endmodule

// File: rtl/bru_top.sv
module bru_top #(
    parameter int ADDR_W  = bru_pkg::ADDR_W,
    parameter int CR_W    = bru_pkg::CR_W,
    parameter int HALF_W  = bru_pkg::HALF_W,
    parameter int DISP_W  = bru_pkg::DISP_W,
    parameter int FIELD_W = bru_pkg::FIELD_W
) (
    input  logic [ADDR_W-1:0]  cia,
    input  logic               indirect,
    input  logic               absolute,
    input  logic [DISP_W-1:0]  disp,
    input  logic [1:0]         xo_sel,
    input  logic [FIELD_W-1:0] bo,
    input  logic [FIELD_W-1:0] bi,
    input  logic               lk,
    input  logic               mode32,
    input  logic [CR_W-1:0]    cr,
    input  logic [ADDR_W-1:0]  ctr_in,
    input  logic [ADDR_W-1:0]  spr_a,
    input  logic [ADDR_W-1:0]  spr_b,
    output logic [ADDR_W-1:0]  nia,
    output logic               nia_valid,
    output logic               lr_we,
    output logic [ADDR_W-1:0]  lr_value,
    output logic [ADDR_W-1:0]  ctr_out,
    output logic               ctr_we
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(bru_pkg::LINK_STEP);

    logic cond_ok;
    logic ctr_ok;

    bru_cond_eval #(.CR_W(CR_W), .FIELD_W(FIELD_W)) u_cond (
        .bo      (bo),
        .bi      (bi),
        .cr      (cr),
        .cond_ok (cond_ok)
    );

    bru_ctr_unit #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .FIELD_W(FIELD_W)) u_ctr (
        .bo      (bo),
        .mode32  (mode32),
        .ctr_in  (ctr_in),
        .ctr_out (ctr_out),
        .ctr_we  (ctr_we),
        .ctr_ok  (ctr_ok)
    );

    bru_target_sel #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
        .indirect (indirect),
        .absolute (absolute),
        .xo_sel   (xo_sel),
        .disp     (disp),
        .cia      (cia),
        .spr_a    (spr_a),
        .spr_b    (spr_b),
        .target   (nia)
    );

    always_comb begin
        nia_valid = cond_ok & ctr_ok;
        lr_we     = lk;
        lr_value  = cia + STEP;
    end

    always_comb begin
        if (nia_valid) begin
            AST_VALID_GATE: assert (cond_ok && ctr_ok); // R6
        end
        if (bo[2]) begin
            AST_NOTEST_PASS: assert (ctr_ok); // R2
        end
        AST_LINK_STEP: assert (lr_value - cia == STEP); // R10
    end
endmodule

// File: tb/bru_top_tb.sv
module bru_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [63:0] cia, ctr_in, spr_a, spr_b;
    logic        indirect, absolute, lk, mode32;
    logic [13:0] disp;
    logic [1:0]  xo_sel;
    logic [4:0]  bo, bi;
    logic [31:0] cr;
    logic [63:0] nia, lr_value, ctr_out;
    logic        nia_valid, lr_we, ctr_we;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bru_top u_dut (
        .cia(cia), .indirect(indirect), .absolute(absolute), .disp(disp),
        .xo_sel(xo_sel), .bo(bo), .bi(bi), .lk(lk), .mode32(mode32),
        .cr(cr), .ctr_in(ctr_in), .spr_a(spr_a), .spr_b(spr_b),
        .nia(nia), .nia_valid(nia_valid), .lr_we(lr_we),
        .lr_value(lr_value), .ctr_out(ctr_out), .ctr_we(ctr_we)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    function automatic logic exp_cond(input logic [4:0] b, input logic [4:0] i, input logic [31:0] c);
        return b[4] | (((c >> (31 - i)) & 32'd1) == {31'd0, b[3]});
    endfunction

    function automatic logic exp_ctr_ok(input logic [4:0] b, input logic m, input logic [63:0] c);
        logic nz;
        nz = m ? (c % 64'h1_0000_0000 != 0) : (c != 0);
        return b[2] | (nz ^ b[1]);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] cvals [4];
        logic [31:0] crp [3];
        cvals[0] = 64'd0; cvals[1] = 64'd1;
        cvals[2] = '1;    cvals[3] = 64'h0000_0005_0000_0000;
        crp[0] = 32'hA5C3_0F81; crp[1] = 32'h8000_0001; crp[2] = 32'h5A3C_F07E;

        // R11: all-zero inputs
        cia = '0; ctr_in = '0; spr_a = '0; spr_b = '0; indirect = 0; absolute = 0;
        lk = 0; mode32 = 0; disp = '0; xo_sel = '0; bo = '0; bi = '0; cr = '0;
        settle();
        chk("R11 nia", nia, 64'd0);
        chk("R11 nia_valid", {63'd0, nia_valid}, 64'd0);
        chk("R11 ctr_out", ctr_out, '1);
        chk("R11 ctr_we", {63'd0, ctr_we}, 64'd1);
        chk("R11 lr_we", {63'd0, lr_we}, 64'd0);
        chk("R11 lr_value", lr_value, 64'd4);

        // R1: condition sweep, count test forced to pass (bo[2]=1)
        ctr_in = 64'd7;
        for (int p = 0; p < 3; p++) begin
            for (int b = 0; b < 32; b++) begin
                for (int i = 0; i < 32; i++) begin
                    cr = crp[p]; bo = 5'(b) | 5'b00100; bi = 5'(i);
                    settle();
                    chk("R1 cond", {63'd0, nia_valid}, {63'd0, exp_cond(bo, bi, cr)});
                end
            end
        end

        // R2 R3 R4 R5 R6: count sweep with both tests meeting in one evaluation
        cr = crp[0]; bi = 5'd3;
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 4; k++) begin
                for (int b = 0; b < 32; b++) begin
                    mode32 = m[0]; ctr_in = cvals[k]; bo = 5'(b);
                    settle();
                    chk("R6 R2 R3 valid", {63'd0, nia_valid},
                        {63'd0, exp_cond(bo, bi, cr) & exp_ctr_ok(bo, mode32, ctr_in)});
                    chk("R4 ctr_out", ctr_out, bo[2] ? ctr_in : ctr_in - 64'd1);
                    chk("R5 ctr_we", {63'd0, ctr_we}, {63'd0, ~bo[2]});
                end
            end
        end

        // R7 R8: indirect source choice and alignment
        indirect = 1; spr_a = 64'h1234_5678_9ABC_DEF3; spr_b = 64'hFEDC_BA98_7654_3211;
        for (int x = 0; x < 4; x++) begin
            xo_sel = 2'(x);
            settle();
            chk("R7 R8 indirect nia", nia,
                (x == 2) ? 64'h1234_5678_9ABC_DEF0 : 64'hFEDC_BA98_7654_3210);
        end

        // R9: direct targets
        indirect = 0;
        for (int a = 0; a < 2; a++) begin
            for (int d = 0; d < 4; d++) begin
                logic [63:0] off;
                absolute = a[0];
                cia = 64'h0000_0000_0010_0000;
                case (d)
                    0: disp = 14'h0000;
                    1: disp = 14'h1FFF;
                    2: disp = 14'h2000;
                    default: disp = 14'h3FFF;
                endcase
                off = {{48{disp[13]}}, disp, 2'b00};
                settle();
                chk("R9 direct nia", nia, a[0] ? off : cia + off);
            end
        end

        // R10: link
        for (int l = 0; l < 2; l++) begin
            lk = l[0]; cia = 64'hFFFF_FFFF_FFFF_FFFC;
            settle();
            chk("R10 lr_we", {63'd0, lr_we}, {63'd0, l[0]});
            chk("R10 lr_value", lr_value, 64'd0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule